// File: doc/BRIEF.md
# Prescaled Up/Down Event Timer

This block is a 16-bit timer for a peripheral bus. Software reaches it through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. A power-of-two prescaler derives the counting rate from the bus clock. The counter counts upward and wraps at a programmable ceiling. It can also count downward and reload from that ceiling when it passes zero.

Down-counting serves as a periodic tick source, or as a single-shot delay when the one-shot option is set. In one-shot mode the timer halts itself at the first underflow. Every underflow raises a sticky flag. Software can set or clear the flag through dedicated write-one registers, and a per-flag enable gates it onto a level interrupt output. Software starts and stops the counter through a command register. It may preload the count only while the timer is halted.

Top module: `ptimer16`

## Requirements
- R1: After reset every register reads zero, the timer is halted and `irq` is low.
- R2: The configuration register at offset 0x00 holds the prescaler exponent in bits 27:24, the clock-source select in bits 17:16, the one-shot enable in bit 4 and the direction in bits 1:0. All other bits read zero. The command (0x04), flag-set (0x14) and flag-clear (0x18) registers always read zero.
- R3: Writing 1 to command bit 0 starts the timer and writing 1 to command bit 1 halts it. A write with both bits set halts it.
- R4: With prescaler exponent k, a running counter changes once every 2^k clock cycles. The first change comes 2^k edges after the edge that accepts the start command.
- R5: With direction 0 (any value other than 1), each tick adds one to the count. A count equal to the ceiling (0x1C) goes to 0 on the next tick, and no flag is raised.
- R6: With direction 1, each tick subtracts one from the count. A count of 0 is reloaded from the ceiling on the next tick, and the same tick sets the underflow flag, bit 1 of the flag register at 0x10.
- R7: With the one-shot bit set, the underflow tick also halts the timer. The count then holds the reloaded ceiling.
- R8: A write to the count register (0x24) loads the count while the timer is halted. The same write is ignored while the timer runs.
- R9: Writing 1 to bit 1 at 0x14 sets the underflow flag and writing 1 to bit 1 at 0x18 clears it. Writes to 0x10 do not change the flag.
- R10: `irq` is high exactly when some flag bit and the matching enable bit (0x0C) are both set.
- R11: With a nonzero clock-source select, the running counter does not advance.
- R12: An underflow in the same cycle as a flag-clear write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, OR of enabled flags |

## Verification
The hardest case to reach is R12: an underflow tick landing on the same edge as a flag-clear write. The bench makes it deterministic. It uses an exponent of 0 so that every running cycle is a tick, preloads a count of zero in down mode, and issues the clear write immediately after the start command. The underflow and the clear then fall on the same edge. The prescaler is swept over several exponents, and the wrap and reload sequences are checked cycle by cycle against arithmetic expectations.

// File: rtl/ptimer16_pkg.sv
package ptimer16_pkg;
   localparam logic [7:0] OFS_CFG   = 8'h00;
   localparam logic [7:0] OFS_CMD   = 8'h04;
   localparam logic [7:0] OFS_MASK  = 8'h0C;
   localparam logic [7:0] OFS_FLAG  = 8'h10;
   localparam logic [7:0] OFS_FSET  = 8'h14;
   localparam logic [7:0] OFS_FCLR  = 8'h18;
   localparam logic [7:0] OFS_CEIL  = 8'h1C;
   localparam logic [7:0] OFS_COUNT = 8'h24;

   localparam int POS_EXP    = 24;
   localparam int POS_SRC    = 16;
   localparam int POS_SINGLE = 4;
   localparam int POS_DIR    = 0;
   localparam int BIT_GO     = 0;
   localparam int BIT_HALT   = 1;
   localparam int BIT_UNDER  = 1;

   localparam logic [1:0] DIR_DOWN = 2'd1;
endpackage

// File: rtl/ptimer16_prescaler.sv
module ptimer16_prescaler #(
   parameter int EXP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [EXP_W-1:0] expo,
   output logic             tick
);
   localparam int DIV_W = (1 << EXP_W) - 1;

   initial begin
      if (EXP_W < 0 || EXP_W > 4) $error("EXP_W must be 0..4");
   end

   generate
      if (EXP_W == 0) begin : g_nodiv
         assign tick = enable;
      end else begin : g_div
         logic [DIV_W-1:0] phase;
         logic [DIV_W-1:0] mask;
         assign mask = {DIV_W{1'b1}} >> (DIV_W - int'(expo));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase <= '0;
            else if (!enable) phase <= '0;
            else              phase <= phase + DIV_W'(1);
         end
         assign tick = enable && ((phase & mask) == mask);
      end
   endgenerate
endmodule

// File: rtl/ptimer16_counter.sv
module ptimer16_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             down,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] ceiling,
   output logic [CNT_W-1:0] count,
   output logic             under
);
   initial begin
      if (CNT_W < 2 || CNT_W > 32) $error("CNT_W must be 2..32");
   end

   assign under = tick && down && (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (tick) begin
         if (down) count <= (count == '0) ? ceiling : count - CNT_W'(1);
         else      count <= (count == ceiling) ? '0 : count + CNT_W'(1);
      end else if (load) begin
         count <= load_val;
      end
   end
endmodule

// File: rtl/ptimer16_flags.sv
module ptimer16_flags #(
   parameter int          FLAG_W = 2,
   parameter logic [31:0] LIVE   = 32'h2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] event_in,
   input  logic              set_wr,
   input  logic              clr_wr,
   input  logic              mask_wr,
   input  logic [FLAG_W-1:0] wbits,
   output logic [FLAG_W-1:0] flags,
   output logic [FLAG_W-1:0] mask,
   output logic              irq
);
   initial begin
      if (FLAG_W < 1 || FLAG_W > 32) $error("FLAG_W must be 1..32");
   end

   for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
      if (LIVE[i]) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               flags[i] <= 1'b0;
               mask[i]  <= 1'b0;
            end else begin
               flags[i] <= event_in[i] | (set_wr & wbits[i]) |
                           (flags[i] & ~(clr_wr & wbits[i]));
               if (mask_wr) mask[i] <= wbits[i];
            end
         end
      end else begin : g_dead
         assign flags[i] = 1'b0;
         assign mask[i]  = 1'b0;
      end
   end

   assign irq = |(flags & mask);
endmodule

// File: rtl/ptimer16.sv
module ptimer16 #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 16,
   parameter int EXP_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq
);
   import ptimer16_pkg::*;

   localparam int FLAG_W = BIT_UNDER + 1;

   initial begin
      if (ADDR_W < 6) $error("ADDR_W must cover the register window");
   end

   logic             sel_cfg, sel_cmd, sel_mask, sel_flag;
   logic             sel_fset, sel_fclr, sel_ceil, sel_count;
   logic [EXP_W-1:0] cfg_exp;
   logic [1:0]       cfg_src, cfg_dir;
   logic             cfg_single;
   logic [CNT_W-1:0] ceil_q, count;
   logic             running, tick, under, down;
   logic [FLAG_W-1:0] flags, mask, events;

   assign sel_cfg   = bus_addr == ADDR_W'(OFS_CFG);
   assign sel_cmd   = bus_addr == ADDR_W'(OFS_CMD);
   assign sel_mask  = bus_addr == ADDR_W'(OFS_MASK);
   assign sel_flag  = bus_addr == ADDR_W'(OFS_FLAG);
   assign sel_fset  = bus_addr == ADDR_W'(OFS_FSET);
   assign sel_fclr  = bus_addr == ADDR_W'(OFS_FCLR);
   assign sel_ceil  = bus_addr == ADDR_W'(OFS_CEIL);
   assign sel_count = bus_addr == ADDR_W'(OFS_COUNT);

   assign down = (cfg_dir == DIR_DOWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_exp    <= '0;
         cfg_src    <= '0;
         cfg_dir    <= '0;
         cfg_single <= 1'b0;
         ceil_q     <= '0;
      end else if (bus_we) begin
         if (sel_cfg) begin
            cfg_exp    <= bus_wdata[POS_EXP +: EXP_W];
            cfg_src    <= bus_wdata[POS_SRC +: 2];
            cfg_dir    <= bus_wdata[POS_DIR +: 2];
            cfg_single <= bus_wdata[POS_SINGLE];
         end
         if (sel_ceil) ceil_q <= bus_wdata[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               running <= 1'b0;
      else if (bus_we && sel_cmd && bus_wdata[BIT_HALT]) running <= 1'b0;
      else if (bus_we && sel_cmd && bus_wdata[BIT_GO])   running <= 1'b1;
      else if (under && cfg_single)             running <= 1'b0;
   end

   ptimer16_prescaler #(.EXP_W(EXP_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .enable (running && (cfg_src == 2'd0)),
      .expo   (cfg_exp),
      .tick   (tick)
   );

   ptimer16_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .down     (down),
      .load     (bus_we && sel_count && !running),
      .load_val (bus_wdata[CNT_W-1:0]),
      .ceiling  (ceil_q),
      .count    (count),
      .under    (under)
   );

   always_comb begin
      events            = '0;
      events[BIT_UNDER] = under;
   end

   ptimer16_flags #(.FLAG_W(FLAG_W), .LIVE(32'(1) << BIT_UNDER)) u_flg (
      .clk      (clk),
      .rst_n    (rst_n),
      .event_in (events),
      .set_wr   (bus_we && sel_fset),
      .clr_wr   (bus_we && sel_fclr),
      .mask_wr  (bus_we && sel_mask),
      .wbits    (bus_wdata[FLAG_W-1:0]),
      .flags    (flags),
      .mask     (mask),
      .irq      (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (sel_cfg) begin
         bus_rdata[POS_EXP +: EXP_W] = cfg_exp;
         bus_rdata[POS_SRC +: 2]     = cfg_src;
         bus_rdata[POS_DIR +: 2]     = cfg_dir;
         bus_rdata[POS_SINGLE]       = cfg_single;
      end else if (sel_mask)  bus_rdata[FLAG_W-1:0] = mask;
      else if (sel_flag)      bus_rdata[FLAG_W-1:0] = flags;
      else if (sel_ceil)      bus_rdata[CNT_W-1:0]  = ceil_q;
      else if (sel_count)     bus_rdata[CNT_W-1:0]  = count;
   end
endmodule

// File: rtl/ptimer16_chk.sv
module ptimer16_chk #(
   parameter int ADDR_W = 8,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [31:0]       bus_wdata,
   input logic              running,
   input logic              tick,
   input logic              under,
   input logic              cfg_single,
   input logic [CNT_W-1:0]  count,
   input logic              flag_under
);
   import ptimer16_pkg::*;

   logic w_cmd, w_cnt, w_clr;
   assign w_cmd = bus_we && bus_addr == ADDR_W'(OFS_CMD);
   assign w_cnt = bus_we && bus_addr == ADDR_W'(OFS_COUNT);
   assign w_clr = bus_we && bus_addr == ADDR_W'(OFS_FCLR);

   a_r3_halt_wins: assert property (@(posedge clk) disable iff (!rst_n)
      w_cmd && bus_wdata[BIT_HALT] |=> !running);

   a_r7_single_halts: assert property (@(posedge clk) disable iff (!rst_n)
      under && cfg_single && !w_cmd |=> !running);

   a_r6_under_flags: assert property (@(posedge clk) disable iff (!rst_n)
      under |=> flag_under);

   a_r8_count_locked: assert property (@(posedge clk) disable iff (!rst_n)
      running && !tick && w_cnt |=> $stable(count));

   a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !running && !w_cnt |=> $stable(count));

   a_r9_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
      w_clr && bus_wdata[BIT_UNDER] && !under |=> !flag_under);
endmodule

bind ptimer16 ptimer16_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_addr   (bus_addr),
   .bus_we     (bus_we),
   .bus_wdata  (bus_wdata),
   .running    (running),
   .tick       (tick),
   .under      (under),
   .cfg_single (cfg_single),
   .count      (count),
   .flag_under (flags[1])
);

// File: tb/ptimer16_test.sv
module ptimer16_test;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_err = 0;
   logic [31:0] v;

   always #(CLK_P/2) clk = ~clk;

   ptimer16 uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int dn_exp(input int s, input int t, input int n);
      if (n <= s) return s - n;
      return t - ((n - s - 1) % (t + 1));
   endfunction

   initial begin
      #(CLK_P * 150000);
      n_err++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      foreach (uut.u_chk.count[i]) ; // no-op placeholder-free loop avoided below
      for (int a = 0; a <= 8'h24; a += 4) begin
         rd(8'(a), v);
         chk("R1 reset register", v, 32'h0);
      end
      chk("R1 reset irq", {31'b0, irq}, 32'h0);

      // R2 field layout and write-only registers
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, v); chk("R2 config readback", v, 32'h0F03_0013);
      wr(8'h00, 32'h0);
      rd(8'h04, v); chk("R2 command reads zero", v, 32'h0);
      wr(8'h14, 32'h0);
      rd(8'h14, v); chk("R2 flag-set reads zero", v, 32'h0);
      rd(8'h18, v); chk("R2 flag-clear reads zero", v, 32'h0);

      // R4 prescaler sweep, up mode with full ceiling
      wr(8'h1C, 32'hFFFF);
      for (int k = 0; k <= 5; k++) begin
         wr(8'h04, 32'h2);
         wr(8'h24, 32'h0);
         wr(8'h00, 32'(k) << 24);
         wr(8'h04, 32'h1);
         edges(40);
         rd(8'h24, v);
         chk($sformatf("R4 exponent %0d", k), v, 32'(40 >> k));
      end

      // R5 up wrap at ceiling, no flag
      wr(8'h04, 32'h2);
      wr(8'h1C, 32'd5);
      wr(8'h24, 32'h0);
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h1);
      for (int n = 1; n <= 14; n++) begin
         edges(1);
         rd(8'h24, v);
         chk($sformatf("R5 up step %0d", n), v, 32'(n % 6));
      end
      rd(8'h10, v); chk("R5 no flag on wrap", v, 32'h0);

      // R6 down count with reload and flag
      wr(8'h04, 32'h2);
      wr(8'h1C, 32'd4);
      wr(8'h24, 32'd2);
      wr(8'h00, 32'h1);
      wr(8'h04, 32'h1);
      for (int n = 1; n <= 14; n++) begin
         edges(1);
         rd(8'h24, v);
         chk($sformatf("R6 down step %0d", n), v, 32'(dn_exp(2, 4, n)));
         if (n == 2) begin
            rd(8'h10, v); chk("R6 flag before underflow", v, 32'h0);
         end
         if (n == 3) begin
            rd(8'h10, v); chk("R6 flag at underflow", v, 32'h2);
         end
      end

      // R7 one-shot
      wr(8'h04, 32'h2);
      wr(8'h18, 32'h2);
      wr(8'h1C, 32'd7);
      wr(8'h24, 32'd1);
      wr(8'h00, 32'h11);
      wr(8'h0C, 32'h2);
      wr(8'h04, 32'h1);
      for (int n = 1; n <= 10; n++) begin
         edges(1);
         rd(8'h24, v);
         chk($sformatf("R7 one-shot step %0d", n), v, (n == 1) ? 32'd0 : 32'd7);
      end
      rd(8'h10, v); chk("R7 flag after one-shot", v, 32'h2);

      // R10 interrupt gating
      chk("R10 irq enabled flag", {31'b0, irq}, 32'h1);
      wr(8'h0C, 32'h0);
      chk("R10 irq masked", {31'b0, irq}, 32'h0);

      // R9 set/clear registers
      wr(8'h18, 32'h2);
      rd(8'h10, v); chk("R9 clear", v, 32'h0);
      wr(8'h10, 32'h2);
      rd(8'h10, v); chk("R9 flag register write ignored", v, 32'h0);
      wr(8'h14, 32'h2);
      rd(8'h10, v); chk("R9 set", v, 32'h2);
      wr(8'h0C, 32'h2);
      chk("R10 irq after set", {31'b0, irq}, 32'h1);
      wr(8'h18, 32'h2);
      chk("R10 irq after clear", {31'b0, irq}, 32'h0);

      // R8 count load only while halted
      wr(8'h24, 32'h55);
      rd(8'h24, v); chk("R8 load while halted", v, 32'h55);
      wr(8'h1C, 32'hFFFF);
      wr(8'h00, 32'h0400_0000);
      wr(8'h04, 32'h1);
      wr(8'h24, 32'h1234);
      rd(8'h24, v); chk("R8 load ignored while running", v, 32'h55);

      // R11 nonzero source select freezes counting
      wr(8'h04, 32'h2);
      wr(8'h24, 32'h0);
      wr(8'h00, 32'h0001_0000);
      wr(8'h04, 32'h1);
      edges(20);
      rd(8'h24, v); chk("R11 alternate source frozen", v, 32'h0);

      // R3 start and halt together
      wr(8'h04, 32'h2);
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h3);
      edges(10);
      rd(8'h24, v); chk("R3 both bits from halted", v, 32'h0);
      wr(8'h04, 32'h1);
      edges(5);
      rd(8'h24, v); chk("R3 started", v, 32'd5);
      wr(8'h04, 32'h3);
      edges(5);
      rd(8'h24, v); chk("R3 both bits halt", v, 32'd6);

      // R12 underflow coincides with clear
      wr(8'h18, 32'h2);
      wr(8'h1C, 32'd3);
      wr(8'h24, 32'h0);
      wr(8'h00, 32'h1);
      wr(8'h04, 32'h1);
      wr(8'h18, 32'h2);
      rd(8'h10, v); chk("R12 underflow beats clear", v, 32'h2);
      rd(8'h24, v); chk("R12 reload on race", v, 32'd3);
      wr(8'h04, 32'h2);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule